// File: doc/BRIEF.md
# Single-Port Block RAM with Selectable Read-During-Write Mode

This block is a synchronous single-port memory of the kind built from on-chip block RAM. It has one clock and one address bus, which reads and writes share. A port enable gates every access. A write enable picks between reading and writing. The data output is registered, so the word at an address appears one clock after that address is presented.

Because reads and writes share the same address, a write cycle also produces an output. The value shown on that output is fixed when the design is elaborated, by a mode parameter. In write-first mode the output shows the incoming data. In read-first mode it shows the word the location held before the write. In no-change mode the output is left untouched.

The mode parameter accepts only the three encodings listed below. Any other value stops elaboration with an error. The depth and the word width are also parameters. Memory contents are not initialised, so a location must be written before it is read.

Top module: `sp_block_ram`

## Requirements
- R1: While the active-low reset is low, and on the first clock after it is released with no access, `rdData` is zero.
- R2: A cycle with `en`=1 and `wrEn`=0 is a read. From the next rising edge, `rdData` shows the word stored at `addr`.
- R3: A cycle with `en`=1 and `wrEn`=1 stores `wrData` at `addr`, in every mode. A later read of that address returns it.
- R4: With `MODE`=0 (write-first), after a write cycle `rdData` equals the `wrData` of that cycle.
- R5: With `MODE`=1 (read-first), after a write cycle `rdData` equals the word the addressed location held before that write.
- R6: With `MODE`=2 (no-change), a write cycle leaves `rdData` at its previous value.
- R7: When `en`=0, no location is written and `rdData` holds its value, whatever `wrEn`, `addr` and `wrData` are.
- R8: Consecutive write cycles to the same address each follow the mode rule. In read-first mode, the second write shows the data stored by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| en | input | 1 | Port enable; no access takes place while low |
| wrEn | input | 1 | Write when high, read when low (only while `en` is high) |
| addr | input | $clog2(DEPTH) | Word address, shared by reads and writes |
| wrData | input | WIDTH | Data to store on a write cycle |
| rdData | output | WIDTH | Registered read data |

## Verification
Assertions check on every cycle the rules that relate the output to the previous cycle's ports. These rules are: the zeroed output under reset, the frozen output while the port is disabled, the echo of written data in write-first mode, and the held output on writes in no-change mode.

Only the bench can show the rules that depend on stored contents. One is that a read returns what an earlier write left. Another is that read-first mode exposes the pre-write word. A third is that a disabled cycle with the write enable raised leaves memory unchanged. The bench covers these through an incrementing fill and readback, mixed stimulus vectors, and same-address write bursts, all applied to three instances, one per mode.

// File: rtl/sp_ram_pkg.sv
package sp_ram_pkg;

  // Read-during-write behaviour selector values
  localparam int MODE_WRITE_FIRST = 0;
  localparam int MODE_READ_FIRST  = 1;
  localparam int MODE_NO_CHANGE   = 2;

  // Strobes from the control to the datapath, valid for the current cycle
  typedef struct packed {
    logic memWrite;      // store wrData at addr on this edge
    logic outLoad;       // update the output register on this edge
    logic outFromInput;  // load wrData instead of the stored word
  } ramStrobe_t;

endpackage

// File: rtl/sp_ram_ctrl.sv
module sp_ram_ctrl
  import sp_ram_pkg::*;
#(
  parameter int MODE = MODE_WRITE_FIRST
) (
  input  logic       en,
  input  logic       wrEn,
  output ramStrobe_t strb
);

  logic wrCycle;
  assign wrCycle = en & wrEn;

  generate
    if (MODE == MODE_WRITE_FIRST) begin : g_writeFirst
      always_comb begin
        strb.memWrite     = wrCycle;
        strb.outLoad      = en;
        strb.outFromInput = wrCycle;
      end
    end else if (MODE == MODE_READ_FIRST) begin : g_readFirst
      always_comb begin
        strb.memWrite     = wrCycle;
        strb.outLoad      = en;
        strb.outFromInput = 1'b0;
      end
    end else if (MODE == MODE_NO_CHANGE) begin : g_noChange
      always_comb begin
        strb.memWrite     = wrCycle;
        strb.outLoad      = en & ~wrEn;
        strb.outFromInput = 1'b0;
      end
    end else begin : g_badMode
      $error("sp_ram_ctrl: MODE must be 0, 1 or 2");
      assign strb = '0;
    end
  endgenerate

endmodule

// File: rtl/sp_ram_datapath.sv
module sp_ram_datapath
  import sp_ram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 18,
  localparam int AddrW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  ramStrobe_t       strb,
  input  logic [AddrW-1:0] addr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] memArray [DEPTH];
  logic [WIDTH-1:0] storedWord;
  logic [WIDTH-1:0] outReg;

  // Storage array: no reset, contents undefined until written
  always_ff @(posedge clk) begin
    if (strb.memWrite) memArray[addr] <= wrData;
  end

  // Pre-write contents at the current address
  assign storedWord = memArray[addr];

  // Registered output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outReg <= '0;
    else if (strb.outLoad)  outReg <= strb.outFromInput ? wrData : storedWord;
  end

  assign rdData = outReg;

  // R2: an enabled access must address an existing word
  p_addr_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    en |-> (int'(addr) < DEPTH))
    else $error("enabled access beyond DEPTH");

endmodule

// File: rtl/sp_block_ram.sv
module sp_block_ram
  import sp_ram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 18,
  parameter int MODE  = MODE_WRITE_FIRST,
  localparam int AddrW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  ramStrobe_t strb;

  sp_ram_ctrl #(.MODE(MODE)) uCtrl (
    .en   (en),
    .wrEn (wrEn),
    .strb (strb)
  );

  sp_ram_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .en     (en),
    .strb   (strb),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData)
  );

  // R1: reset clears the output register
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (rdData == '0))
    else $error("output not zero after reset");

  // R7: a disabled port freezes the output
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(rdData))
    else $error("output moved while disabled");

  generate
    if (MODE == MODE_WRITE_FIRST) begin : g_chkWriteFirst
      // R4: write-first echoes the written data
      p_write_echo_r4: assert property (@(posedge clk) disable iff (!rstN)
        (en && wrEn) |=> (rdData == $past(wrData)))
        else $error("write-first output mismatch");
    end else if (MODE == MODE_NO_CHANGE) begin : g_chkNoChange
      // R6: no-change keeps the output across a write
      p_write_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
        (en && wrEn) |=> $stable(rdData))
        else $error("no-change output moved on write");
    end
  endgenerate

endmodule

// File: tb/sim_sp_block_ram.sv
`timescale 1ns/1ps
module sim_sp_block_ram;

  localparam int DEPTH = 16;
  localparam int WIDTH = 16;
  localparam int AW    = 4;
  localparam int NVEC  = 14;

  // Vector fields: {en, wrEn, addr[3:0], wrData[15:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 4'd3,  16'hA5A5},
    {1'b1, 1'b0, 4'd3,  16'h0000},
    {1'b0, 1'b1, 4'd3,  16'hFFFF},
    {1'b0, 1'b0, 4'd7,  16'h1111},
    {1'b1, 1'b0, 4'd3,  16'h0000},
    {1'b1, 1'b1, 4'd7,  16'h1234},
    {1'b1, 1'b1, 4'd8,  16'h5678},
    {1'b1, 1'b0, 4'd7,  16'h0000},
    {1'b1, 1'b0, 4'd8,  16'h0000},
    {1'b0, 1'b1, 4'd8,  16'hDEAD},
    {1'b1, 1'b0, 4'd8,  16'h0000},
    {1'b1, 1'b1, 4'd0,  16'hBEEF},
    {1'b0, 1'b0, 4'd0,  16'h0000},
    {1'b1, 1'b0, 4'd0,  16'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] q0, q1, q2;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  logic [WIDTH-1:0] refMem [DEPTH];
  bit               refOk  [DEPTH];
  logic [WIDTH-1:0] expQ   [3];
  bit               expOk  [3];

  always #2.5 clk = ~clk;

  sp_block_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(0)) u0 (
    .clk(clk), .rstN(rstN), .en(en), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(q0));
  sp_block_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(1)) u1 (
    .clk(clk), .rstN(rstN), .en(en), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(q1));
  sp_block_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(2)) u2 (
    .clk(clk), .rstN(rstN), .en(en), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(q2));

  function automatic logic [WIDTH-1:0] getQ(int m);
    return (m == 0) ? q0 : (m == 1) ? q1 : q2;
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic compare(int m, string tag);
    if (expOk[m]) begin
      nChecks++;
      if (getQ(m) !== expQ[m]) begin
        nFails++;
        $display("FAIL %s mode %0d addr %0d: got %h expected %h", tag, m, addr, getQ(m), expQ[m]);
      end
    end
  endtask

  // One cycle: drive at negedge, model at posedge, sample 1 ns later.
  // readTag names the requirement of a read; b2b marks same-address bursts (R8).
  task automatic step(logic e, logic w, logic [AW-1:0] a, logic [WIDTH-1:0] d,
                      string readTag, bit b2b);
    string tg [3];
    @(negedge clk);
    en = e; wrEn = w; addr = a; wrData = d;
    @(posedge clk);
    if (!e) begin
      tg = '{"R7", "R7", "R7"};
    end else if (w) begin
      tg = b2b ? '{"R8", "R8", "R8"} : '{"R4", "R5", "R6"};
      expQ[0] = d; expOk[0] = 1'b1;
      expQ[1] = refMem[a]; expOk[1] = refOk[a];
      refMem[a] = d; refOk[a] = 1'b1;
    end else begin
      tg = '{readTag, readTag, readTag};
      for (int m = 0; m < 3; m++) begin
        expQ[m] = refMem[a]; expOk[m] = refOk[a];
      end
    end
    #1;
    for (int m = 0; m < 3; m++) compare(m, tg[m]);
  endtask

  task automatic resetCheck();
    @(negedge clk);
    rstN = 1'b0; en = 1'b0; wrEn = 1'b0;
    @(posedge clk); #1;
    for (int m = 0; m < 3; m++) begin
      expQ[m] = '0; expOk[m] = 1'b1;
      compare(m, "R1");
    end
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    for (int m = 0; m < 3; m++) compare(m, "R1");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nFails++;
        $display("FAIL watchdog: got %0d cycles expected at most 20000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      refMem[i] = '0; refOk[i] = 1'b0;
    end
    for (int m = 0; m < 3; m++) begin
      expQ[m] = '0; expOk[m] = 1'b0;
    end

    // R1: initial reset
    repeat (3) @(posedge clk);
    resetCheck();

    // R3: incrementing fill of every address, then read back (R2 latency)
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 1'b1, AW'(i), 16'h1000 + WIDTH'(i), "R3", 1'b0);
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 1'b0, AW'(i), 16'h0000, "R3", 1'b0);

    // Mixed stimulus vectors (R2, R4..R7)
    for (int v = 0; v < NVEC; v++)
      step(VEC[v][21], VEC[v][20], VEC[v][19:16], VEC[v][15:0], "R2", 1'b0);

    // R8: back-to-back writes to one address, then readback
    step(1'b1, 1'b1, 4'd5, 16'hC001, "R8", 1'b1);
    step(1'b1, 1'b1, 4'd5, 16'hC002, "R8", 1'b1);
    step(1'b1, 1'b1, 4'd5, 16'hC003, "R8", 1'b1);
    step(1'b1, 1'b0, 4'd5, 16'h0000, "R8", 1'b0);
    step(1'b1, 1'b1, 4'd15, 16'h7E7E, "R8", 1'b1);
    step(1'b1, 1'b1, 4'd15, 16'h0101, "R8", 1'b1);
    step(1'b1, 1'b0, 4'd15, 16'h0000, "R8", 1'b0);

    // R1: reset mid-run clears the output; memory keeps contents (R3)
    resetCheck();
    step(1'b1, 1'b0, 4'd15, 16'h0000, "R3", 1'b0);
    step(1'b1, 1'b0, 4'd9, 16'h0000, "R3", 1'b0);

    finishRun();
  end

endmodule